// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block is the command front end of an on-chip flash array. A CPU writes command bytes to it over a simple write port. Some commands take one bus cycle: read status, clear status, read array. Others take two: program, block erase and erase-all. When a two-cycle command is complete and valid, the block raises a request to the flash array model and holds the operation kind, address and data until the array reports done together with a pass or fail flag.

The block keeps a status byte with three live bits. Bit 7 is a ready flag. Bits 5 and 4 are error flags. The pair of error bits encodes the kind of failure:

| Bit 5 | Bit 4 | Meaning |
|---|---|---|
| 1 | 1 | Malformed command |
| 1 | 0 | Erase failure |
| 0 | 1 | Program failure |

While either error bit is set, the block refuses new program and erase commands until software clears the status. A read-select output tells the bus whether reads should return array data or the status byte.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte is 0x80, read-select is 0 (array data) and no operation is requested.
- R2: First-cycle byte 0x40 followed by any second write starts a program. The block raises op_req with op_kind 0 and the address and data of the second write. It holds op_req and those values stable until op_done.
- R3: First-cycle byte 0x20 followed by 0xD0 starts a block erase (op_kind 1) at the second write's address. First-cycle byte 0xA7 followed by 0x20 starts an erase-all (op_kind 2).
- R4: A second-cycle byte of 0xFF after 0x20 or 0xA7 cancels the pending command. No operation starts, no error bit is set, and read-select returns to 0.
- R5: Any second-cycle byte after 0x20 other than 0xD0 or 0xFF sets status bits 5 and 4. The same applies after 0xA7 for any byte other than 0x20 or 0xFF. No operation starts.
- R6: A first-cycle byte that is not one of 0x40, 0x20, 0xA7, 0x70, 0x50 or 0xFF sets status bits 5 and 4.
- R7: An erase that completes with op_pass low sets status bit 5 and leaves bit 4 at 0.
- R8: A program that completes with op_pass low sets status bit 4 and leaves bit 5 at 0.
- R9: While bit 4 or bit 5 is set, first-cycle bytes 0x40, 0x20 and 0xA7 are ignored. No request is made, the status is unchanged, and the next write is again decoded as a first cycle.
- R10: First-cycle byte 0x50 clears status bits 5 and 4.
- R11: Writes made while an operation is in progress are ignored.
- R12: Byte 0x70 sets read-select to 1 and byte 0xFF (as a first cycle) sets it to 0. Starting an operation, or a malformed command, also sets it to 1.
- R13: Status bit 7 reads 0 from the cycle after an operation is started until the cycle after op_done, and reads 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Address of the bus write |
| wr_data | input | 8 | Command or data byte of the bus write |
| rd_status_sel | output | 1 | 1: reads return the status byte; 0: reads return array data |
| op_req | output | 1 | Operation request to the array, held until op_done |
| op_kind | output | 2 | 0 program, 1 block erase, 2 erase-all |
| op_addr | output | ADDR_W | Target address of the operation |
| op_data | output | 8 | Program data (confirm byte for erases) |
| op_done | input | 1 | Array finished the requested operation |
| op_pass | input | 1 | Outcome qualifier valid with op_done |
| status | output | 8 | Status byte: bit 7 ready, bit 5 and bit 4 error code |

## Verification
The assertions assume that the array model raises op_done only while op_req is high and that it holds op_pass valid in the same cycle. They also assume that wr_en is a single-cycle strobe for each bus write. The bench's array model answers only after it has seen op_req, and it pulses op_done for exactly one cycle. Each bus write is driven for one cycle, with the strobe dropped between writes. Writes that arrive during a busy period are made deliberately, to exercise the rule that they are ignored.

// File: rtl/fcs_pkg.sv
// Shared types for the flash command sequencer.
// Assumes 8-bit command bytes; status bit positions are fixed here.
package fcs_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Class of a byte written as a first bus cycle.
    typedef enum logic [2:0] {
        CMD_PROG,
        CMD_ERASE_BLK,
        CMD_ERASE_ALL,
        CMD_RD_STATUS,
        CMD_CLR_STATUS,
        CMD_RD_ARRAY,
        CMD_BAD
    } cmd_e;

    // Operation kinds handed to the array (encoding visible on op_kind).
    typedef enum logic [1:0] {
        OP_PROG      = 2'd0,
        OP_ERASE_BLK = 2'd1,
        OP_ERASE_ALL = 2'd2
    } op_e;

    // Sequencer phase.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SECOND,
        ST_BUSY
    } state_e;

    localparam int SR_READY_BIT = 7;
    localparam int SR_ERASE_BIT = 5;
    localparam int SR_PROG_BIT  = 4;
endpackage

// File: rtl/fcs_decode.sv
// First-cycle command decoder.
// Purely combinational: maps a written byte onto a command class.
// Assumes all opcode parameters are distinct.
module fcs_decode
    import fcs_pkg::*;
#(
    parameter byte_t OPC_PROG      = 8'h40,
    parameter byte_t OPC_ERASE_BLK = 8'h20,
    parameter byte_t OPC_ERASE_ALL = 8'hA7,
    parameter byte_t OPC_RD_STATUS = 8'h70,
    parameter byte_t OPC_CLR       = 8'h50,
    parameter byte_t OPC_RD_ARRAY  = 8'hFF
) (
    input  byte_t data,
    output cmd_e  cmd
);
    // Compare the byte against every known opcode; anything else is malformed.
    always_comb begin
        if (data == OPC_PROG)                cmd = CMD_PROG;
        else if (data == OPC_ERASE_BLK)      cmd = CMD_ERASE_BLK;
        else if (data == OPC_ERASE_ALL)      cmd = CMD_ERASE_ALL;
        else if (data == OPC_RD_STATUS)      cmd = CMD_RD_STATUS;
        else if (data == OPC_CLR)            cmd = CMD_CLR_STATUS;
        else if (data == OPC_RD_ARRAY)       cmd = CMD_RD_ARRAY;
        else                                 cmd = CMD_BAD;
    end
endmodule

// File: rtl/fcs_sequencer.sv
// Command sequencer: tracks first/second bus cycles, launches array
// operations and reports events that update the status register.
// Assumes op_done is only raised while op_req is high, and that wr_en
// marks exactly one bus write per asserted cycle.
module fcs_sequencer
    import fcs_pkg::*;
#(
    parameter int    ADDR_W     = 16,
    parameter byte_t CONF_ERASE = 8'hD0,
    parameter byte_t CONF_ALL   = 8'h20,
    parameter byte_t ESCAPE     = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  cmd_e              cmd,
    input  logic              err_pending,
    input  logic              op_done,
    input  logic              op_pass,
    output logic              busy,
    output logic              op_req,
    output op_e               op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output byte_t             op_data,
    output logic              ev_seq_err,
    output logic              ev_prog_fail,
    output logic              ev_erase_fail,
    output logic              ev_clear,
    output logic              ev_mode_status,
    output logic              ev_mode_array
);
    state_e            state_q, state_d;
    op_e               pend_q, pend_d;
    op_e               kind_q, kind_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    byte_t             data_q, data_d;
    byte_t             confirm;

    // Expected confirm byte for the pending erase flavour.
    always_comb confirm = (pend_q == OP_ERASE_ALL) ? CONF_ALL : CONF_ERASE;

    // Next-state and event logic for the command protocol.
    always_comb begin
        state_d        = state_q;
        pend_d         = pend_q;
        kind_d         = kind_q;
        addr_d         = addr_q;
        data_d         = data_q;
        ev_seq_err     = 1'b0;
        ev_prog_fail   = 1'b0;
        ev_erase_fail  = 1'b0;
        ev_clear       = 1'b0;
        ev_mode_status = 1'b0;
        ev_mode_array  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    unique case (cmd)
                        CMD_PROG: if (!err_pending) begin
                            state_d = ST_SECOND;
                            pend_d  = OP_PROG;
                        end
                        CMD_ERASE_BLK: if (!err_pending) begin
                            state_d = ST_SECOND;
                            pend_d  = OP_ERASE_BLK;
                        end
                        CMD_ERASE_ALL: if (!err_pending) begin
                            state_d = ST_SECOND;
                            pend_d  = OP_ERASE_ALL;
                        end
                        CMD_RD_STATUS:  ev_mode_status = 1'b1;
                        CMD_CLR_STATUS: ev_clear       = 1'b1;
                        CMD_RD_ARRAY:   ev_mode_array  = 1'b1;
                        default: begin
                            ev_seq_err     = 1'b1;
                            ev_mode_status = 1'b1;
                        end
                    endcase
                end
            end
            ST_SECOND: begin
                if (wr_en) begin
                    if (pend_q == OP_PROG || wr_data == confirm) begin
                        state_d        = ST_BUSY;
                        kind_d         = pend_q;
                        addr_d         = wr_addr;
                        data_d         = wr_data;
                        ev_mode_status = 1'b1;
                    end else if (wr_data == ESCAPE) begin
                        state_d       = ST_IDLE;
                        ev_mode_array = 1'b1;
                    end else begin
                        state_d        = ST_IDLE;
                        ev_seq_err     = 1'b1;
                        ev_mode_status = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                    if (!op_pass) begin
                        if (kind_q == OP_PROG) ev_prog_fail  = 1'b1;
                        else                   ev_erase_fail = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= OP_PROG;
            kind_q  <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            kind_q  <= kind_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
        end
    end

    // Drive the array handshake from the registered operation.
    always_comb begin
        busy    = (state_q == ST_BUSY);
        op_req  = busy;
        op_kind = kind_q;
        op_addr = addr_q;
        op_data = data_q;
    end

    // A request stays up until the array answers.
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_done) |=> op_req);

    // Operation fields never move while the request is outstanding; bus writes are ignored.
    assert_op_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_done) |=> ($stable(op_addr) && $stable(op_kind) && $stable(op_data)));

    // With an error pending, program/erase openers leave the sequencer idle.
    assert_blocked_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_en && err_pending &&
         (cmd == CMD_PROG || cmd == CMD_ERASE_BLK || cmd == CMD_ERASE_ALL))
        |=> (state_q == ST_IDLE && !op_req));

    // Escape in the second cycle of an erase returns to idle without an error.
    assert_escape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND && wr_en && pend_q != OP_PROG && wr_data == ESCAPE)
        |=> (state_q == ST_IDLE && !err_pending && !op_req));
endmodule

// File: rtl/fcs_status.sv
// Status register and read-mode selector.
// Holds the two error bits and the read-select flag; ready comes from
// the sequencer. Assumes at most one error/clear event per cycle.
module fcs_status
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ready,
    input  logic  ev_seq_err,
    input  logic  ev_prog_fail,
    input  logic  ev_erase_fail,
    input  logic  ev_clear,
    input  logic  ev_mode_status,
    input  logic  ev_mode_array,
    output byte_t status,
    output logic  err_pending,
    output logic  rd_status_sel
);
    logic err_prog_q, err_erase_q, sel_q;

    // Error bits: set by the event that names them, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_prog_q  <= 1'b0;
            err_erase_q <= 1'b0;
        end else if (ev_clear) begin
            err_prog_q  <= 1'b0;
            err_erase_q <= 1'b0;
        end else begin
            if (ev_seq_err || ev_prog_fail)  err_prog_q  <= 1'b1;
            if (ev_seq_err || ev_erase_fail) err_erase_q <= 1'b1;
        end
    end

    // Read-mode flag: status view or array view.
    always_ff @(posedge clk) begin
        if (!rst_n)              sel_q <= 1'b0;
        else if (ev_mode_status) sel_q <= 1'b1;
        else if (ev_mode_array)  sel_q <= 1'b0;
    end

    // Assemble the visible status byte.
    always_comb begin
        status               = '0;
        status[SR_READY_BIT] = ready;
        status[SR_ERASE_BIT] = err_erase_q;
        status[SR_PROG_BIT]  = err_prog_q;
        err_pending          = err_prog_q | err_erase_q;
        rd_status_sel        = sel_q;
    end

    // Events from the sequencer never coincide.
    assert_events_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_seq_err, ev_prog_fail, ev_erase_fail, ev_clear}));

    // Clear request empties both error bits.
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clear |=> (status[SR_PROG_BIT] == 1'b0 && status[SR_ERASE_BIT] == 1'b0));

    // Malformed command sets both error bits.
    assert_seq_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_seq_err |=> (status[SR_PROG_BIT] && status[SR_ERASE_BIT]));

    // Erase failure flags only the erase bit, starting from a clean state.
    assert_erase_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_erase_fail && !err_pending) |=> (status[SR_ERASE_BIT] && !status[SR_PROG_BIT]));

    // Program failure flags only the program bit, starting from a clean state.
    assert_prog_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_prog_fail && !err_pending) |=> (status[SR_PROG_BIT] && !status[SR_ERASE_BIT]));
endmodule

// File: rtl/flash_cmd_seq.sv
// Flash command sequencer top level.
// Wires the first-cycle decoder, the protocol sequencer and the status
// register together. Assumes a single clock and synchronous active-low reset.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int    ADDR_W        = 16,
    parameter byte_t OPC_PROG      = 8'h40,
    parameter byte_t OPC_ERASE_BLK = 8'h20,
    parameter byte_t OPC_ERASE_ALL = 8'hA7,
    parameter byte_t OPC_RD_STATUS = 8'h70,
    parameter byte_t OPC_CLR       = 8'h50,
    parameter byte_t OPC_RD_ARRAY  = 8'hFF,
    parameter byte_t CONF_ERASE    = 8'hD0,
    parameter byte_t CONF_ALL      = 8'h20,
    parameter byte_t ESCAPE        = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              rd_status_sel,
    output logic              op_req,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    input  logic              op_done,
    input  logic              op_pass,
    output logic [7:0]        status
);
    cmd_e cmd;
    op_e  kind;
    logic busy, err_pending;
    logic ev_seq_err, ev_prog_fail, ev_erase_fail, ev_clear, ev_mode_status, ev_mode_array;

    fcs_decode #(
        .OPC_PROG      (OPC_PROG),
        .OPC_ERASE_BLK (OPC_ERASE_BLK),
        .OPC_ERASE_ALL (OPC_ERASE_ALL),
        .OPC_RD_STATUS (OPC_RD_STATUS),
        .OPC_CLR       (OPC_CLR),
        .OPC_RD_ARRAY  (OPC_RD_ARRAY)
    ) u_decode (
        .data (wr_data),
        .cmd  (cmd)
    );

    fcs_sequencer #(
        .ADDR_W     (ADDR_W),
        .CONF_ERASE (CONF_ERASE),
        .CONF_ALL   (CONF_ALL),
        .ESCAPE     (ESCAPE)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .cmd            (cmd),
        .err_pending    (err_pending),
        .op_done        (op_done),
        .op_pass        (op_pass),
        .busy           (busy),
        .op_req         (op_req),
        .op_kind        (kind),
        .op_addr        (op_addr),
        .op_data        (op_data),
        .ev_seq_err     (ev_seq_err),
        .ev_prog_fail   (ev_prog_fail),
        .ev_erase_fail  (ev_erase_fail),
        .ev_clear       (ev_clear),
        .ev_mode_status (ev_mode_status),
        .ev_mode_array  (ev_mode_array)
    );

    fcs_status u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .ready          (!busy),
        .ev_seq_err     (ev_seq_err),
        .ev_prog_fail   (ev_prog_fail),
        .ev_erase_fail  (ev_erase_fail),
        .ev_clear       (ev_clear),
        .ev_mode_status (ev_mode_status),
        .ev_mode_array  (ev_mode_array),
        .status         (status),
        .err_pending    (err_pending),
        .rd_status_sel  (rd_status_sel)
    );

    // Export the operation kind as a plain two-bit code.
    always_comb op_kind = kind;

    // Ready reads low exactly while a request is outstanding.
    assert_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] == !op_req);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_status_sel, op_req, op_done = 1'b0, op_pass = 1'b0;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data, status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_status_sel(rd_status_sel), .op_req(op_req), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_done(op_done), .op_pass(op_pass),
        .status(status)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One bus write, driven between falling edges; outputs are sampled after return.
    task automatic bus_write(logic [7:0] d, logic [AW-1:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Array model: answer an outstanding request after a few cycles.
    task automatic array_answer(logic pass);
        repeat (3) @(negedge clk);
        op_done = 1'b1; op_pass = pass;
        @(negedge clk);
        op_done = 1'b0; op_pass = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "status", status, 8'h80);
        check("R1", "rd_sel", rd_status_sel, 0);
        check("R1", "op_req", op_req, 0);
    endtask

    task automatic t_read_modes();
        bus_write(8'h70, 0);
        check("R12", "rd_sel after 0x70", rd_status_sel, 1);
        bus_write(8'hFF, 0);
        check("R12", "rd_sel after 0xFF", rd_status_sel, 0);
    endtask

    task automatic t_program_pass();
        bus_write(8'h40, 16'h0000);
        check("R2", "no req after first cycle", op_req, 0);
        bus_write(8'h3C, 16'h1234);
        check("R2", "op_req", op_req, 1);
        check("R2", "op_kind", op_kind, 0);
        check("R2", "op_addr", op_addr, 16'h1234);
        check("R2", "op_data", op_data, 8'h3C);
        check("R13", "busy status", status, 8'h00);
        check("R12", "rd_sel on accept", rd_status_sel, 1);
        bus_write(8'hFF, 16'h5555);
        bus_write(8'h50, 16'h7777);
        check("R11", "rd_sel during busy", rd_status_sel, 1);
        check("R11", "op_addr during busy", op_addr, 16'h1234);
        check("R11", "op_req during busy", op_req, 1);
        array_answer(1'b1);
        check("R13", "ready after done", status, 8'h80);
        check("R2", "req dropped", op_req, 0);
    endtask

    task automatic t_program_fail_and_block();
        bus_write(8'h40, 0);
        bus_write(8'h11, 16'h0042);
        array_answer(1'b0);
        check("R8", "program fail code", status, 8'h90);
        bus_write(8'h20, 16'h0100);
        check("R9", "blocked erase no req", op_req, 0);
        check("R9", "blocked status", status, 8'h90);
        bus_write(8'h40, 16'h0100);
        check("R9", "blocked program no req", op_req, 0);
        bus_write(8'h50, 0);
        check("R9", "next write decoded as first cycle", status, 8'h80);
        check("R10", "cleared", status, 8'h80);
    endtask

    task automatic t_block_erase_fail();
        bus_write(8'h20, 0);
        bus_write(8'hD0, 16'h0A00);
        check("R3", "erase req", op_req, 1);
        check("R3", "erase kind", op_kind, 1);
        check("R3", "erase addr", op_addr, 16'h0A00);
        array_answer(1'b0);
        check("R7", "erase fail code", status, 8'hA0);
        bus_write(8'h50, 0);
        check("R10", "cleared after erase fail", status, 8'h80);
    endtask

    task automatic t_erase_all();
        bus_write(8'hA7, 0);
        bus_write(8'h20, 0);
        check("R3", "erase-all req", op_req, 1);
        check("R3", "erase-all kind", op_kind, 2);
        array_answer(1'b1);
        check("R3", "erase-all ok", status, 8'h80);
    endtask

    task automatic t_escape();
        bus_write(8'h70, 0);
        bus_write(8'h20, 0);
        bus_write(8'hFF, 0);
        check("R4", "no req on escape", op_req, 0);
        check("R4", "no error on escape", status, 8'h80);
        check("R4", "array mode on escape", rd_status_sel, 0);
        bus_write(8'hA7, 0);
        bus_write(8'hFF, 0);
        check("R4", "erase-all escape status", status, 8'h80);
        bus_write(8'h70, 0);
        check("R4", "idle again after escape", rd_status_sel, 1);
        bus_write(8'hFF, 0);
    endtask

    task automatic t_bad_confirm();
        bus_write(8'h20, 0);
        bus_write(8'h55, 0);
        check("R5", "bad block confirm", status, 8'hB0);
        check("R5", "no req", op_req, 0);
        check("R12", "status view on error", rd_status_sel, 1);
        bus_write(8'h50, 0);
        bus_write(8'hA7, 0);
        bus_write(8'hD0, 0);
        check("R5", "bad erase-all confirm", status, 8'hB0);
        bus_write(8'h50, 0);
        check("R10", "cleared sequence error", status, 8'h80);
    endtask

    task automatic t_unknown();
        bus_write(8'h12, 0);
        check("R6", "unknown opcode", status, 8'hB0);
        bus_write(8'h50, 0);
        check("R10", "cleared unknown", status, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_modes();
        t_program_pass();
        t_program_fail_and_block();
        t_block_erase_fail();
        t_erase_all();
        t_escape();
        t_bad_confirm();
        t_unknown();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule